// File: doc/BRIEF.md
# Residue-Multiplication Conversion Sequencer

This block holds the digital timing and counting for a multi-phase integrating converter. A binary sequence counter steps through one conversion of fixed length: zero-integrate, signal integrate, a hundreds-weighted deintegration, an idle fill, a times-ten residue gain, a tens-weighted deintegration, a second times-ten gain and a ones-weighted deintegration. The block drives one-hot phase selects to the analog switches and the deintegration polarity. It samples a single comparator bit that reports the sign of the integrator.

Each deintegration pass starts at a fixed point in the sequence. It runs until the comparator reports a crossing or until its window runs out. During the pass a five-digit decimal up/down counter moves by that pass's weight. At the end of every conversion the counter is copied to a result register and EOC pulses. Negative readings are held as decimal complements modulo 100000. Conversions run back to back unless hold is requested. Mode inputs set the integrate length, and a read-zero request shorts the input for a whole conversion.

Top module: `convSequencer`

## Requirements
- R1: A conversion lasts exactly CONV_LEN clocks, measured as the cycle index from its first clock to the cycle in which eoc is high. With hold low, eoc pulses every CONV_LEN clocks. The first conversion after hold falls starts on the clock edge after hold is seen low.
- R2: The integrate phase (phaseSel bit 1) lasts INT_60 clocks when sel50Hz is 0, INT_50 clocks when it is 1, and INT_OHM clocks when ohmsMode is 1 regardless of sel50Hz. divFive divides the selected length by DIVF. The mode inputs are sampled when a conversion starts.
- R3: phaseSel is one-hot, with bit 0 zero-integrate, bit 1 integrate, bit 2 deintegrate-1, bit 3 idle, bit 4 times-ten-1, bit 5 deintegrate-2, bit 6 times-ten-2 and bit 7 deintegrate-3. Integrate ends at a fixed point, so deintegrate-1 always begins at cycle index ZI_MIN+INT_50. Each times-ten phase lasts TEN_LEN clocks.
- R4: The polarity of each deintegration pass is the comparator value sampled on the last clock before the pass, and it is shown on deintPol. Polarity 1 counts up and polarity 0 counts down.
- R5: A pass steps the counter once for every clock on which the comparator still equals the pass polarity. The first differing clock ends the pass: that clock still shows the deintegrate phase, and idle (bit 3) follows until the window ends.
- R6: The counter steps by 100 in deintegrate-1, by 10 in deintegrate-2 and by 1 in deintegrate-3.
- R7: A pass whose comparator never crosses ends when its window runs out. The windows are DE1_WIN, DE2_WIN, and the rest of the conversion for the third pass. The count stands at that point.
- R8: resultBcd holds five BCD digits, ones in bits 3:0 and upward. A negative value v is encoded as 100000+v, so zero is 00000, -1 is 99999 and -25000 is 75000. Every digit stays at 9 or below.
- R9: At the end of each conversion the counter is copied to resultBcd, and eoc is high for exactly that one following cycle. resultBcd does not change in any cycle in which eoc is low.
- R10: If holdReq is high at the last clock of a conversion, the block stops after that conversion and stays in zero-integrate with no eoc until holdReq falls.
- R11: A conversion started with readZero high asserts shortIn on every one of its clocks. shortIn is low while the block is stopped.
- R12: The counter reads zero after every integrate clock, and it does not change across a times-ten phase.
- R13: After reset the block is stopped in zero-integrate, with eoc and shortIn low and resultBcd zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequence clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpPos | input | 1 | Comparator: 1 when the integrator output is positive |
| holdReq | input | 1 | Stop after the current conversion while high |
| readZero | input | 1 | Make the next conversion a shorted-input conversion |
| sel50Hz | input | 1 | Select the 50 Hz integrate length |
| ohmsMode | input | 1 | Select the ohms integrate length |
| divFive | input | 1 | Divide the integrate length by DIVF |
| phaseSel | output | 8 | One-hot phase select to the analog switches |
| deintPol | output | 1 | Polarity of the current deintegration pass |
| shortIn | output | 1 | Input-short select for a read-zero conversion |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| resultBcd | output | 20 | Latched five-digit decimal-complement result |

## Verification
The bench builds the block with a 66-clock conversion, 12-clock deintegration windows, 3-clock times-ten phases and integrate lengths of 15, 20 and 10 clocks with a divider of 5. At this scale each pass can cross at every offset from the first window clock through overrun, and one run covers every polarity combination. The bench's integrator model answers the phase selects with a comparator crossing chosen for each pass. The expected result and the phase lengths are computed from signed weighted sums reduced modulo 100000. A sweep over all eight mode combinations, with and without read-zero, checks the integrate length and the short select. Free-running and hold sequences check the conversion period and the stopping point.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    PH_ZI   = 3'd0,
    PH_INT  = 3'd1,
    PH_DE1  = 3'd2,
    PH_IDLE = 3'd3,
    PH_TEN1 = 3'd4,
    PH_DE2  = 3'd5,
    PH_TEN2 = 3'd6,
    PH_DE3  = 3'd7
  } phase_e;

  typedef struct packed {
    logic       clr;
    logic       step;
    logic       down;
    logic [2:0] pos;
    logic       capture;
  } strobe_t;

endpackage

// File: rtl/bcdDigit.sv
module bcdDigit (
  input  logic [3:0] dIn,
  input  logic       addIn,
  input  logic       down,
  output logic [3:0] dOut,
  output logic       carryOut
);
  always_comb begin
    dOut     = dIn;
    carryOut = 1'b0;
    if (addIn) begin
      if (down) begin
        if (dIn == 4'd0) begin
          dOut     = 4'd9;
          carryOut = 1'b1;
        end else begin
          dOut = dIn - 4'd1;
        end
      end else begin
        if (dIn >= 4'd9) begin
          dOut     = 4'd0;
          carryOut = 1'b1;
        end else begin
          dOut = dIn + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/bcdAccum.sv
module bcdAccum
  import seq_pkg::*;
#(
  parameter int NDIG = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  output logic [4*NDIG-1:0] accBcd,
  output logic [4*NDIG-1:0] resultBcd
);
  localparam int RW = 4 * NDIG;

  logic [RW-1:0] accQ, accNext, resQ;
  logic [NDIG:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic addIn;
    assign addIn = strb.step && ((strb.pos == 3'(i)) || carry[i]);
    bcdDigit u_dig (
      .dIn      (accQ[4*i +: 4]),
      .addIn    (addIn),
      .down     (strb.down),
      .dOut     (accNext[4*i +: 4]),
      .carryOut (carry[i+1])
    );

    p_digit_range_r8: assert property (@(posedge clk) disable iff (rst)
      accQ[4*i +: 4] <= 4'd9)
      else $error("accumulator digit out of range");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ <= '0;
      resQ <= '0;
    end else begin
      if (strb.clr)       accQ <= '0;
      else if (strb.step) accQ <= accNext;
      if (strb.capture)   resQ <= accQ;
    end
  end

  assign accBcd    = accQ;
  assign resultBcd = resQ;
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import seq_pkg::*;
#(
  parameter int CONV_LEN = 1638,
  parameter int ZI_MIN   = 100,
  parameter int INT_60   = 545,
  parameter int INT_50   = 655,
  parameter int INT_OHM  = 500,
  parameter int DIVF     = 5,
  parameter int DE1_WIN  = 500,
  parameter int TEN_LEN  = 16,
  parameter int DE2_WIN  = 200
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cmpPos,
  input  logic    holdReq,
  input  logic    readZero,
  input  logic    sel50Hz,
  input  logic    ohmsMode,
  input  logic    divFive,
  output logic [7:0] phaseSel,
  output logic    deintPol,
  output logic    shortIn,
  output logic    eoc,
  output strobe_t strb
);
  localparam int CW         = $clog2(CONV_LEN);
  localparam int INT_END    = ZI_MIN + INT_50;
  localparam int TEN1_START = INT_END + DE1_WIN;
  localparam int DE2_START  = TEN1_START + TEN_LEN;
  localparam int TEN2_START = DE2_START + DE2_WIN;
  localparam int DE3_START  = TEN2_START + TEN_LEN;

  localparam logic [CW-1:0] S_DE1   = CW'(INT_END);
  localparam logic [CW-1:0] S_TEN1  = CW'(TEN1_START);
  localparam logic [CW-1:0] S_DE2   = CW'(DE2_START);
  localparam logic [CW-1:0] S_TEN2  = CW'(TEN2_START);
  localparam logic [CW-1:0] S_DE3   = CW'(DE3_START);
  localparam logic [CW-1:0] S_LAST  = CW'(CONV_LEN - 1);
  localparam logic [CW-1:0] S_PRE1  = CW'(INT_END - 1);
  localparam logic [CW-1:0] S_PRE2  = CW'(DE2_START - 1);
  localparam logic [CW-1:0] S_PRE3  = CW'(DE3_START - 1);
  localparam logic [CW-1:0] L_60    = CW'(INT_60);
  localparam logic [CW-1:0] L_50    = CW'(INT_50);
  localparam logic [CW-1:0] L_OHM   = CW'(INT_OHM);
  localparam logic [CW-1:0] L_60D   = CW'(INT_60 / DIVF);
  localparam logic [CW-1:0] L_50D   = CW'(INT_50 / DIVF);
  localparam logic [CW-1:0] L_OHMD  = CW'(INT_OHM / DIVF);

  logic [CW-1:0] seqCnt, intLen, intStart;
  logic          held, cfg50, cfgOhm, cfgDiv, cfgRz;
  logic          pol, deDone, eocQ;
  logic          atLast, startEdge, preDe, inDe;
  phase_e        curPhase;

  // integrate length from the mode snapshot
  always_comb begin
    if (cfgOhm)     intLen = cfgDiv ? L_OHMD : L_OHM;
    else if (cfg50) intLen = cfgDiv ? L_50D  : L_50;
    else            intLen = cfgDiv ? L_60D  : L_60;
  end
  assign intStart = S_DE1 - intLen;

  always_comb begin
    if (held)                  curPhase = PH_ZI;
    else if (seqCnt < intStart) curPhase = PH_ZI;
    else if (seqCnt < S_DE1)   curPhase = PH_INT;
    else if (seqCnt < S_TEN1)  curPhase = deDone ? PH_IDLE : PH_DE1;
    else if (seqCnt < S_DE2)   curPhase = PH_TEN1;
    else if (seqCnt < S_TEN2)  curPhase = deDone ? PH_IDLE : PH_DE2;
    else if (seqCnt < S_DE3)   curPhase = PH_TEN2;
    else if (seqCnt < S_LAST)  curPhase = deDone ? PH_IDLE : PH_DE3;
    else                       curPhase = PH_ZI;
  end

  assign atLast    = !held && (seqCnt == S_LAST);
  assign startEdge = (held && !holdReq) || atLast;
  assign preDe     = !held && ((seqCnt == S_PRE1) || (seqCnt == S_PRE2) || (seqCnt == S_PRE3));
  assign inDe      = (curPhase == PH_DE1) || (curPhase == PH_DE2) || (curPhase == PH_DE3);

  always_ff @(posedge clk) begin
    if (rst) begin
      seqCnt <= '0;
      held   <= 1'b1;
      cfg50  <= 1'b0;
      cfgOhm <= 1'b0;
      cfgDiv <= 1'b0;
      cfgRz  <= 1'b0;
      pol    <= 1'b0;
      deDone <= 1'b0;
      eocQ   <= 1'b0;
    end else begin
      eocQ <= atLast;
      if (held) begin
        if (!holdReq) held <= 1'b0;
      end else if (atLast) begin
        seqCnt <= '0;
        held   <= holdReq;
      end else begin
        seqCnt <= seqCnt + 1'b1;
      end
      if (startEdge) begin
        cfg50  <= sel50Hz;
        cfgOhm <= ohmsMode;
        cfgDiv <= divFive;
        cfgRz  <= readZero;
      end
      if (preDe) begin
        pol    <= cmpPos;
        deDone <= 1'b0;
      end else if (inDe && (cmpPos != pol)) begin
        deDone <= 1'b1;
      end
    end
  end

  always_comb begin
    phaseSel           = '0;
    phaseSel[curPhase] = 1'b1;
    strb.clr     = (curPhase == PH_INT);
    strb.step    = inDe && (cmpPos == pol);
    strb.down    = !pol;
    strb.pos     = (curPhase == PH_DE1) ? 3'd2 : (curPhase == PH_DE2) ? 3'd1 : 3'd0;
    strb.capture = atLast;
  end

  assign deintPol = pol;
  assign shortIn  = cfgRz && !held;
  assign eoc      = eocQ;

  p_pol_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_DE1) && $past(curPhase == PH_DE1) |-> $stable(pol))
    else $error("polarity moved inside a pass");

  p_short_whole_r11: assert property (@(posedge clk) disable iff (rst)
    !held && (seqCnt != '0) |-> $stable(shortIn))
    else $error("short select changed mid conversion");

  p_hold_parked_r10: assert property (@(posedge clk) disable iff (rst)
    held && holdReq |=> (seqCnt == '0) && !eoc)
    else $error("sequence moved while held");
endmodule

// File: rtl/convSequencer.sv
module convSequencer
  import seq_pkg::*;
#(
  parameter int CONV_LEN = 1638,
  parameter int ZI_MIN   = 100,
  parameter int INT_60   = 545,
  parameter int INT_50   = 655,
  parameter int INT_OHM  = 500,
  parameter int DIVF     = 5,
  parameter int DE1_WIN  = 500,
  parameter int TEN_LEN  = 16,
  parameter int DE2_WIN  = 200,
  parameter int NDIG     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpPos,
  input  logic              holdReq,
  input  logic              readZero,
  input  logic              sel50Hz,
  input  logic              ohmsMode,
  input  logic              divFive,
  output logic [7:0]        phaseSel,
  output logic              deintPol,
  output logic              shortIn,
  output logic              eoc,
  output logic [4*NDIG-1:0] resultBcd
);
  strobe_t           strb;
  logic [4*NDIG-1:0] accBcd;

  seqCtrl #(
    .CONV_LEN (CONV_LEN), .ZI_MIN (ZI_MIN), .INT_60 (INT_60), .INT_50 (INT_50),
    .INT_OHM  (INT_OHM),  .DIVF   (DIVF),   .DE1_WIN (DE1_WIN),
    .TEN_LEN  (TEN_LEN),  .DE2_WIN (DE2_WIN)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmpPos   (cmpPos),
    .holdReq  (holdReq),
    .readZero (readZero),
    .sel50Hz  (sel50Hz),
    .ohmsMode (ohmsMode),
    .divFive  (divFive),
    .phaseSel (phaseSel),
    .deintPol (deintPol),
    .shortIn  (shortIn),
    .eoc      (eoc),
    .strb     (strb)
  );

  bcdAccum #(.NDIG (NDIG)) u_accum (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .accBcd    (accBcd),
    .resultBcd (resultBcd)
  );

  p_int_clear_r12: assert property (@(posedge clk) disable iff (rst)
    phaseSel[1] |=> (accBcd == '0))
    else $error("counter not cleared in integrate");

  p_ten_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    (phaseSel[4] || phaseSel[6]) |=> $stable(accBcd))
    else $error("counter moved during times-ten");

  p_result_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !eoc |-> $stable(resultBcd))
    else $error("result changed without eoc");

  p_eoc_single_r9: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc)
    else $error("eoc wider than one cycle");

  p_phase_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $countones(phaseSel) == 1)
    else $error("phase select not one-hot");
endmodule

// File: tb/sim_convSequencer.sv
module sim_convSequencer;
  localparam int CONV_LEN = 66;
  localparam int ZI_MIN   = 3;
  localparam int INT_60   = 15;
  localparam int INT_50   = 20;
  localparam int INT_OHM  = 10;
  localparam int DIVF     = 5;
  localparam int DE1_WIN  = 12;
  localparam int TEN_LEN  = 3;
  localparam int DE2_WIN  = 12;
  localparam int DE1S     = ZI_MIN + INT_50;
  localparam int DE3S     = DE1S + DE1_WIN + TEN_LEN + DE2_WIN + TEN_LEN;
  localparam int DE3_WIN  = CONV_LEN - 1 - DE3S;

  logic clk = 1'b0, rst = 1'b1;
  logic cmpPos = 1'b0, holdReq = 1'b1, readZero = 1'b0;
  logic sel50Hz = 1'b0, ohmsMode = 1'b0, divFive = 1'b0;
  logic [7:0]  phaseSel;
  logic        deintPol, shortIn, eoc;
  logic [19:0] resultBcd;

  int nChk = 0, nBad = 0;

  always #10 clk = ~clk;

  convSequencer #(
    .CONV_LEN (CONV_LEN), .ZI_MIN (ZI_MIN), .INT_60 (INT_60), .INT_50 (INT_50),
    .INT_OHM  (INT_OHM),  .DIVF   (DIVF),   .DE1_WIN (DE1_WIN),
    .TEN_LEN  (TEN_LEN),  .DE2_WIN (DE2_WIN), .NDIG (5)
  ) u0 (
    .clk (clk), .rst (rst), .cmpPos (cmpPos), .holdReq (holdReq),
    .readZero (readZero), .sel50Hz (sel50Hz), .ohmsMode (ohmsMode),
    .divFive (divFive), .phaseSel (phaseSel), .deintPol (deintPol),
    .shortIn (shortIn), .eoc (eoc), .resultBcd (resultBcd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int toBcd(input int v);
    int m = ((v % 100000) + 100000) % 100000;
    int r = 0;
    for (int i = 0; i < 5; i++) begin
      r = r | ((m % 10) << (4 * i));
      m = m / 10;
    end
    return r;
  endfunction

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int expSum(input bit p1, input bit p2, input bit p3,
                                input int n1, input int n2, input int n3);
    int s1 = p1 ? 1 : -1;
    int s2 = p2 ? 1 : -1;
    int s3 = p3 ? 1 : -1;
    return s1 * 100 * minI(n1, DE1_WIN) + s2 * 10 * minI(n2, DE2_WIN) + s3 * minI(n3, DE3_WIN);
  endfunction

  function automatic int phIdx(input logic [7:0] ps);
    int r = -1;
    for (int i = 0; i < 8; i++) if (ps[i]) r = i;
    return r;
  endfunction

  // one conversion from the held state, with a scripted comparator crossing per pass
  task automatic runConv(input bit s50, input bit ohm, input bit dv, input bit rz,
                         input bit p1, input bit p2, input bit p3,
                         input int n1, input int n2, input int n3);
    int cnt[8];
    int total = 0, shortCnt = 0, de1First = -1, guard = 0, k1 = 0, k2 = 0, k3 = 0;
    int base, expInt, expRes, ph, oneHotBad = 0;
    bit done = 0;
    logic [19:0] resSeen;
    for (int i = 0; i < 8; i++) cnt[i] = 0;
    @(negedge clk);
    sel50Hz = s50; ohmsMode = ohm; divFive = dv; readZero = rz;
    holdReq = 1'b0; cmpPos = 1'b0;
    while (!done) begin
      @(negedge clk);
      holdReq = 1'b1;
      guard++;
      if (eoc) done = 1;
      else begin
        ph = phIdx(phaseSel);
        if ($countones(phaseSel) != 1) oneHotBad++;
        if (ph >= 0) cnt[ph]++;
        if (shortIn) shortCnt++;
        if (ph == 2 && de1First < 0) de1First = total;
        total++;
        case (ph)
          1: cmpPos = p1;
          2: begin cmpPos = (k1 < n1) ? p1 : !p1; k1++; end
          4: cmpPos = p2;
          5: begin cmpPos = (k2 < n2) ? p2 : !p2; k2++; end
          6: cmpPos = p3;
          7: begin cmpPos = (k3 < n3) ? p3 : !p3; k3++; end
          default: ;
        endcase
        if (guard > 4 * CONV_LEN) begin
          done = 1;
          chk(0, "R1 conversion never ended", total, CONV_LEN);
        end
      end
    end
    resSeen = resultBcd;
    base   = ohm ? INT_OHM : (s50 ? INT_50 : INT_60);
    expInt = dv ? base / DIVF : base;
    expRes = toBcd(expSum(p1, p2, p3, n1, n2, n3));
    chk(total == CONV_LEN, "R1 conversion length", total, CONV_LEN);
    chk(cnt[1] == expInt, "R2 integrate length", cnt[1], expInt);
    chk(oneHotBad == 0 && de1First == DE1S, "R3 one-hot / deintegrate-1 start", de1First, DE1S);
    chk(cnt[4] == TEN_LEN && cnt[6] == TEN_LEN, "R3 times-ten lengths", cnt[4] + cnt[6], 2 * TEN_LEN);
    chk(cnt[2] == minI(n1 + 1, DE1_WIN), "R5 R7 deintegrate-1 cycles", cnt[2], minI(n1 + 1, DE1_WIN));
    chk(cnt[5] == minI(n2 + 1, DE2_WIN), "R5 R7 deintegrate-2 cycles", cnt[5], minI(n2 + 1, DE2_WIN));
    chk(cnt[7] == minI(n3 + 1, DE3_WIN), "R5 R7 deintegrate-3 cycles", cnt[7], minI(n3 + 1, DE3_WIN));
    chk(resSeen == 20'(expRes), "R4 R6 R8 result", int'(resSeen), expRes);
    chk(shortCnt == (rz ? CONV_LEN : 0), "R11 short select cycles", shortCnt, rz ? CONV_LEN : 0);
    @(negedge clk);
    chk(!eoc && resultBcd == resSeen, "R9 eoc single / result held", int'(eoc), 0);
    cmpPos = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    int gap;
    bit sawEoc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(phaseSel == 8'h01 && !eoc && !shortIn && resultBcd == 20'h0,
        "R13 reset state", int'(phaseSel), 1);

    // free run, comparator held low: every pass runs its full window counting down (R1 R7)
    holdReq = 1'b0; cmpPos = 1'b0;
    gap = 0;
    while (!eoc && gap < 4 * CONV_LEN) begin @(negedge clk); gap++; end
    chk(resultBcd == 20'(toBcd(-(100 * DE1_WIN + 10 * DE2_WIN + DE3_WIN))),
        "R7 R8 full-window negative result", int'(resultBcd),
        toBcd(-(100 * DE1_WIN + 10 * DE2_WIN + DE3_WIN)));
    gap = 0;
    do begin @(negedge clk); gap++; end while (!eoc && gap < 4 * CONV_LEN);
    chk(gap == CONV_LEN, "R1 free-running eoc period", gap, CONV_LEN);
    holdReq = 1'b1;
    gap = 0;
    do begin @(negedge clk); gap++; end while (!eoc && gap < 4 * CONV_LEN);
    chk(gap == CONV_LEN, "R10 hold waits for conversion end", gap, CONV_LEN);
    sawEoc = 0;
    for (int i = 0; i < 3 * CONV_LEN; i++) begin
      @(negedge clk);
      if (eoc || phaseSel != 8'h01) sawEoc = 1;
    end
    chk(!sawEoc, "R10 stays in zero-integrate while held", int'(sawEoc), 0);

    // directed values
    runConv(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);     // -1 -> 99999
    runConv(0, 0, 0, 0, 1, 1, 1, 20, 20, 20);  // full-window positive
    runConv(1, 0, 0, 1, 1, 0, 1, 4, 7, 2);     // mixed signs, read-zero
    runConv(0, 0, 0, 0, 1, 1, 1, 0, 0, 0);     // immediate crossings -> 00000

    // mode sweep with and without read-zero
    for (int c = 0; c < 16; c++)
      runConv(c[0], c[1], c[2], c[3], !c[0], c[1], !c[2],
              c % 14, (c * 3) % 14, (c * 5 + 1) % 14);

    // crossing offset sweep over every polarity combination
    for (int n = 0; n < 14; n++)
      for (int p = 0; p < 8; p++)
        runConv(n[0], 0, 0, 0, p[0], p[1], p[2], n, (n * 5) % 14, (n * 7 + 3) % 14);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule